// File: doc/BRIEF.md
# High-Speed Master Pull-Up Controller

This block drives the enable of the current-source pull-up on the clock line of a high-speed I2C master. It watches the master's own sampled SCLH and SDAH levels, a flag that says whether this master currently owns the bus, and a one-cycle pulse that marks the switch into high-speed mode. From these it works out whether the master is in a high-speed transfer and where the current bit sits within its byte.

The pull-up is driven only while this master owns a high-speed transfer. When the falling clock edge ends each acknowledge slot, the pull-up is released so that any device can hold the clock low. It comes back on at the first rising clock level seen after that. A STOP returns the block to Fast/Standard behaviour, where the pull-up stays off. A repeated START keeps high-speed mode and restarts the byte. The block does not produce the serial waveforms themselves.

Top module: `hs_pullup_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `pullup_en_o` is 0.
- R2: While `active_master_i` is 0, `hs_enter_i` pulses have no effect and `pullup_en_o` stays 0.
- R3: If no `hs_enter_i` pulse has been accepted, SCL/SDA activity leaves `pullup_en_o` at 0. This includes START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high).
- R4: An `hs_enter_i` pulse while `active_master_i` is 1 enters high-speed mode with the bit count at 0, and `pullup_en_o` becomes 1.
- R5: In high-speed mode each SCL rising edge advances the bit count from 1 to 9 and then wraps to 1. The pull-up stays on through bits 1 to 8 and through the rising edge of bit 9.
- R6: The SCL falling edge that ends bit 9 (the acknowledge slot) turns `pullup_en_o` off. It stays off for as long as SCL is held low.
- R7: After that acknowledge release, the first SCL rising edge turns `pullup_en_o` back on.
- R8: A repeated START during high-speed mode sets the bit count to 0 and leaves the block in high-speed mode. The next release then follows the ninth rising edge after the START.
- R9: A STOP during high-speed mode turns `pullup_en_o` off and returns the block to Fast/Standard mode. Later bits do not turn it back on.
- R10: When `active_master_i` falls, `pullup_en_o` is 0 one cycle later and the high-speed state is lost. Raising the flag again does not restore the pull-up without a new `hs_enter_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_sense_i | input | 1 | Sampled SCLH line level (asynchronous) |
| sda_sense_i | input | 1 | Sampled SDAH line level (asynchronous) |
| active_master_i | input | 1 | This master currently owns the bus |
| hs_enter_i | input | 1 | One-cycle pulse: high-speed mode entered |
| pullup_en_o | output | 1 | Current-source pull-up enable (registered) |

## Verification
The bench builds the block with two synchroniser stages and the standard nine-bit frame. It holds every line level for six clocks, which covers the three-cycle path from pin to output with margin. With a frame this small, the bench can sweep every bit position of several bytes and place a repeated START after each of the eight non-acknowledge bit counts. The expected pull-up level is derived from the bit index alone. STOP is exercised both inside a byte and while the clock is released after an acknowledge.

// File: rtl/hs_pu_pkg.sv
package hs_pu_pkg;

  typedef enum logic [1:0] {
    ST_FS    = 2'd0,  // Fast/Standard: pull-up off
    ST_DRIVE = 2'd1,  // high-speed, pull-up driven
    ST_HOLD  = 2'd2   // high-speed, released after acknowledge
  } pu_state_e;

endpackage

// File: rtl/hs_line_sync.sv
module hs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic prev_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Idle bus lines are high; resetting to 1 avoids spurious edges.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q[0] <= line_i;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign prev_o  = prev_q;

endmodule

// File: rtl/hs_bus_cond.sv
module hs_bus_cond (
  input  logic scl_level_i,
  input  logic scl_prev_i,
  input  logic sda_level_i,
  input  logic sda_prev_i,
  output logic start_o,
  output logic stop_o
);

  logic scl_steady_high;

  // Only accept SDA edges while SCL has been high for two samples.
  assign scl_steady_high = scl_level_i & scl_prev_i;
  assign start_o = scl_steady_high & sda_prev_i & ~sda_level_i;
  assign stop_o  = scl_steady_high & ~sda_prev_i & sda_level_i;

endmodule

// File: rtl/hs_bit_tracker.sv
module hs_bit_tracker #(
  parameter int FRAME_BITS = 9,
  localparam int CW = $clog2(FRAME_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          rise_i,
  output logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      count_q <= '0;
    end else if (rise_i) begin
      count_q <= (count_q == LAST) ? CW'(1) : count_q + CW'(1);
    end
  end

  assign count_o = count_q;

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count_q <= LAST);  // R5

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && !rise_i) |=> $stable(count_q));  // R5

endmodule

// File: rtl/hs_pullup_ctrl.sv
module hs_pullup_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 9,
  localparam int CW = $clog2(FRAME_BITS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_sense_i,
  input  logic sda_sense_i,
  input  logic active_master_i,
  input  logic hs_enter_i,
  output logic pullup_en_o
);
  import hs_pu_pkg::*;

  localparam logic [CW-1:0] ACK_SLOT = CW'(FRAME_BITS);

  logic scl_level, scl_prev, sda_level, sda_prev;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic cnt_clear;
  logic [CW-1:0] bit_cnt;
  pu_state_e state_q, state_d;
  logic pullup_q;

  hs_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .line_i(scl_sense_i),
    .level_o(scl_level), .prev_o(scl_prev)
  );

  hs_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .line_i(sda_sense_i),
    .level_o(sda_level), .prev_o(sda_prev)
  );

  assign scl_rise = scl_level & ~scl_prev;
  assign scl_fall = ~scl_level & scl_prev;

  hs_bus_cond u_cond (
    .scl_level_i(scl_level), .scl_prev_i(scl_prev),
    .sda_level_i(sda_level), .sda_prev_i(sda_prev),
    .start_o(start_det), .stop_o(stop_det)
  );

  hs_bit_tracker #(.FRAME_BITS(FRAME_BITS)) u_bits (
    .clk(clk), .rst(rst), .clear_i(cnt_clear),
    .rise_i(scl_rise), .count_o(bit_cnt)
  );

  // Priority: ownership loss, mode entry, STOP, repeated START, clock edges.
  always_comb begin
    state_d   = state_q;
    cnt_clear = 1'b0;
    if (!active_master_i) begin
      state_d = ST_FS;
    end else if (hs_enter_i) begin
      state_d   = ST_DRIVE;
      cnt_clear = 1'b1;
    end else begin
      unique case (state_q)
        ST_DRIVE: begin
          if (stop_det)                              state_d = ST_FS;
          else if (start_det)                        cnt_clear = 1'b1;
          else if (scl_fall && bit_cnt == ACK_SLOT)  state_d = ST_HOLD;
        end
        ST_HOLD: begin
          if (stop_det)       state_d = ST_FS;
          else if (start_det) cnt_clear = 1'b1;
          else if (scl_rise)  state_d = ST_DRIVE;
        end
        default: state_d = ST_FS;
      endcase
    end
    if (state_d == ST_FS) cnt_clear = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FS;
      pullup_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      pullup_q <= (state_d == ST_DRIVE);
    end
  end

  assign pullup_en_o = pullup_q;

  AST_PASSIVE_OFF: assert property (@(posedge clk) disable iff (rst)
    !active_master_i |=> !pullup_en_o);  // R10

  AST_ENTER_ON: assert property (@(posedge clk) disable iff (rst)
    (active_master_i && hs_enter_i) |=> pullup_en_o);  // R4

  AST_STOP_OFF: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !hs_enter_i) |=> !pullup_en_o);  // R9

  AST_ACK_OFF: assert property (@(posedge clk) disable iff (rst)
    (pullup_en_o && scl_fall && bit_cnt == ACK_SLOT && active_master_i && !hs_enter_i)
      |=> !pullup_en_o);  // R6

  AST_RELEASE_ON: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && scl_rise && active_master_i) |=> pullup_en_o);  // R7

  AST_SR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_FS && start_det && active_master_i) |=> (bit_cnt == '0));  // R8

endmodule

// File: tb/hs_pullup_ctrl_tb.sv
`timescale 1ns/1ps
module hs_pullup_ctrl_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic act = 1'b0;
  logic hs_go = 1'b0;
  logic pu;
  int   checks = 0;
  int   fails  = 0;

  always #2 clk = ~clk;

  hs_pullup_ctrl #(.SYNC_STAGES(2), .FRAME_BITS(9)) u_dut (
    .clk(clk), .rst(rst), .scl_sense_i(scl), .sda_sense_i(sda),
    .active_master_i(act), .hs_enter_i(hs_go), .pullup_en_o(pu)
  );

  task automatic check(input string req, input logic exp_v);
    checks++;
    if (pu !== exp_v) begin
      fails++;
      $display("FAIL %s: pullup_en=%0b expected %0b", req, pu, exp_v);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic drive(input logic c, input logic d);
    scl = c;
    sda = d;
    settle();
  endtask

  task automatic pulse_enter();
    @(negedge clk) hs_go = 1'b1;
    @(negedge clk) hs_go = 1'b0;
    settle();
  endtask

  task automatic do_sr();
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
  endtask

  task automatic do_stop();
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
  endtask

  // One data bit; idx is its 1-based position after the last clear.
  task automatic clock_bit(input int idx, input string rtag, input logic exp_hi,
                           input logic exp_lo);
    logic d;
    d = logic'(idx % 2);
    drive(1'b0, d);
    drive(1'b1, d);
    check(rtag, exp_hi);
    drive(1'b0, d);
    check(rtag, exp_lo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 1'b0);
    settle();

    // R3: active master, but no high-speed entry
    act = 1'b1;
    do_sr();
    check("R3", 1'b0);
    for (int b = 1; b <= 9; b++) clock_bit(b, "R3", 1'b0, 1'b0);
    do_stop();
    check("R3", 1'b0);

    // R2: not the owner, entry pulse ignored
    act = 1'b0;
    settle();
    pulse_enter();
    check("R2", 1'b0);
    do_sr();
    for (int b = 1; b <= 9; b++) clock_bit(b, "R2", 1'b0, 1'b0);

    // R4 / R5 / R6 / R7: full bytes with clock stretch after each ack
    act = 1'b1;
    settle();
    pulse_enter();
    check("R4", 1'b1);
    do_sr();
    check("R8", 1'b1);
    for (int byte_i = 0; byte_i < 3; byte_i++) begin
      for (int b = 1; b <= 9; b++) begin
        clock_bit(b, (b == 9) ? "R6" : ((b == 1 && byte_i > 0) ? "R7" : "R5"),
                  1'b1, (b == 9) ? 1'b0 : 1'b1);
      end
      repeat (20) @(negedge clk);
      check("R6", 1'b0);
    end

    // R8: repeated START after every non-ack bit count
    for (int p = 1; p <= 8; p++) begin
      for (int b = 1; b <= p; b++) clock_bit(b, (b == 1) ? "R7" : "R5", 1'b1, 1'b1);
      do_sr();
      check("R8", 1'b1);
      for (int b = 1; b <= 9; b++) begin
        clock_bit(b, "R8", 1'b1, (b == 9) ? 1'b0 : 1'b1);
      end
    end

    // R9: STOP while released after ack, then bits stay off
    do_stop();
    check("R9", 1'b0);
    for (int b = 1; b <= 9; b++) clock_bit(b, "R9", 1'b0, 1'b0);
    do_stop();

    // R9: STOP in the middle of a byte
    pulse_enter();
    do_sr();
    for (int b = 1; b <= 4; b++) clock_bit(b, "R5", 1'b1, 1'b1);
    do_stop();
    check("R9", 1'b0);
    for (int b = 1; b <= 9; b++) clock_bit(b, "R9", 1'b0, 1'b0);

    // R10: ownership lost mid-transfer
    pulse_enter();
    do_sr();
    for (int b = 1; b <= 3; b++) clock_bit(b, "R5", 1'b1, 1'b1);
    act = 1'b0;
    @(negedge clk);
    check("R10", 1'b0);
    act = 1'b1;
    settle();
    check("R10", 1'b0);
    for (int b = 4; b <= 12; b++) clock_bit(b, "R10", 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule